// File: doc/BRIEF.md
# MSI L1 Line Coherence Controller

This block is the coherence state machine for one line of a private first-level cache in a directory-based MSI protocol. Each cycle it takes at most one event. An event can be a processor load or store, a replacement chosen by the cache, a forwarded request or invalidation from the directory, an eviction acknowledgement, or a data or invalidation-acknowledge response from the directory or a peer cache. The event comes as a code on `ev_code`. Data from the directory also carries an expected acknowledgement count on `ev_acks`.

For each event the block works out the next line state. In the same cycle it raises one-cycle strobes that tell the surrounding cache what to do: issue a read-share or read-own request, issue a clean or dirty put, send data to the requester and/or the directory, send an invalidation acknowledgement, or complete a load or store hit. It also reports the access-permission class of the current state. It keeps a signed count of invalidation acknowledgements still owed. Acknowledgements that arrive before the data drive this count negative. When the last owed acknowledgement is accounted for, the block creates an internal last-acknowledge event and the line becomes Modified. Events that must wait are refused with a stall. Events that are impossible in the current state set a sticky protocol-error flag and change nothing.

Top module: `msi_l1_line_ctrl`

## Requirements
- R1: After synchronous reset the state is I (code 0), the permission is absent (code 0), the ack count is 0, the error flag is low and no strobe is raised.
- R2: State codes are I=0, IS_D=1, IM_AD=2, IM_A=3, S=4, SM_AD=5, SM_A=6, M=7, MI_A=8, SI_A=9, II_A=10. Permission codes are: absent=0 for I; invalid=1 for IS_D, IM_AD, II_A; busy=2 for IM_A, MI_A, SI_A; read-only=3 for S, SM_AD, SM_A; read-write=4 for M.
- R3: Event codes are load=0, store=1, replacement=2, fwd-read=3, fwd-own=4, invalidate=5, put-ack=6, dir-data=7, owner-data=8, inv-ack=9. Codes 10 to 15 are illegal. A load in I issues a read-share request and goes to IS_D. A store in I goes to IM_AD with a read-own request, and a store in S goes to SM_AD with a read-own request. A load hits in S, SM_AD, SM_A and M. A store hits in M.
- R4: Dir-data with `ev_acks` equal to 0, and owner-data, complete the request: IS_D goes to S with a load hit, and IM_AD or SM_AD go to M with a store hit. Dir-data with a nonzero count in IM_AD or SM_AD adds the count to the ack counter and goes to IM_A or SM_A.
- R5: Inv-ack decrements the ack counter in IM_AD, SM_AD, IM_A and SM_A. The counter may go negative. The last-ack strobe and a store hit are raised, the state becomes M and the counter returns to 0 when either (a) an inv-ack in IM_A or SM_A brings the counter to 0, or (b) dir-data with a nonzero count in IM_AD or SM_AD brings the sum to 0. In I, S and M the counter is 0.
- R6: Only an owner sends data. Fwd-read in M sends data to requester and directory and goes to S. In MI_A it does the same and goes to SI_A. Fwd-own in M sends data to the requester and goes to I. In MI_A it does the same and goes to II_A.
- R7: Replacement in S issues a clean put and goes to SI_A. Replacement in M issues a dirty put and goes to MI_A. Put-ack in MI_A, SI_A or II_A returns the line to I.
- R8: Invalidate sends an inv-ack and moves S to I, SM_AD to IM_AD, and SI_A to II_A.
- R9: Stalled pairs raise stall, leave state and counter unchanged and raise no other strobe. The stalled pairs are:
  - load in any busy or invalid-permission transient state;
  - store in any transient state;
  - replacement in any transient state;
  - fwd-read or fwd-own in IM_AD, IM_A, SM_AD or SM_A;
  - invalidate in IS_D.
- R10: Any other event/state pair, and any illegal code, sets a sticky protocol-error flag. Such an event leaves state and counter unchanged and raises no strobe. The flag clears only on reset. An idle cycle (`ev_valid` low) changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | An event is presented this cycle |
| ev_code | input | 4 | Event code (R3) |
| ev_acks | input | 8 | Signed expected ack count carried by dir-data |
| state_o | output | 4 | Current line state code (R2) |
| perm_o | output | 3 | Permission class of the current state (R2) |
| ack_cnt_o | output | 8 | Signed outstanding-ack count |
| stall_o | output | 1 | Event must be retried later |
| load_hit_o | output | 1 | Load completes this cycle |
| store_hit_o | output | 1 | Store completes this cycle |
| req_gets_o | output | 1 | Send read-share request to directory |
| req_getm_o | output | 1 | Send read-own request to directory |
| req_puts_o | output | 1 | Send clean put to directory |
| req_putm_o | output | 1 | Send dirty put with data to directory |
| rsp_data_req_o | output | 1 | Send data to the forwarded requester |
| rsp_data_dir_o | output | 1 | Send data to the directory |
| rsp_inv_ack_o | output | 1 | Send invalidation acknowledgement |
| last_ack_o | output | 1 | Internal last-acknowledge event fired |
| protocol_error_o | output | 1 | Sticky illegal-event flag |

## Verification
The transition table is driven along complete transactions from each stable state: read fill, write fill from I and from S, writeback, downgrade and eviction races. Together these separate every transient state's exit path. Acknowledgement ordering is tried three ways: acks after the data, acks before the data so that the counter goes negative, and early acks that cancel the data's count exactly. These cases tell apart a counter that wraps, saturates or fires too early. Stalled and illegal pairs are placed between legal steps, so that a state or counter disturbed by a refused event shows up in the next legal transition.

// File: rtl/msi_l1_pkg.sv
package msi_l1_pkg;

    localparam int ST_W   = 4;
    localparam int CODE_W = 4;
    localparam int PERM_W = 3;

    typedef enum logic [ST_W-1:0] {
        ST_I     = 4'd0,
        ST_IS_D  = 4'd1,
        ST_IM_AD = 4'd2,
        ST_IM_A  = 4'd3,
        ST_S     = 4'd4,
        ST_SM_AD = 4'd5,
        ST_SM_A  = 4'd6,
        ST_M     = 4'd7,
        ST_MI_A  = 4'd8,
        ST_SI_A  = 4'd9,
        ST_II_A  = 4'd10
    } line_state_e;

    typedef enum logic [PERM_W-1:0] {
        PERM_ABSENT  = 3'd0,
        PERM_INVALID = 3'd1,
        PERM_BUSY    = 3'd2,
        PERM_RO      = 3'd3,
        PERM_RW      = 3'd4
    } perm_e;

    localparam logic [CODE_W-1:0] CODE_LOAD    = 4'd0;
    localparam logic [CODE_W-1:0] CODE_STORE   = 4'd1;
    localparam logic [CODE_W-1:0] CODE_REPL    = 4'd2;
    localparam logic [CODE_W-1:0] CODE_FWD_RD  = 4'd3;
    localparam logic [CODE_W-1:0] CODE_FWD_OWN = 4'd4;
    localparam logic [CODE_W-1:0] CODE_INV     = 4'd5;
    localparam logic [CODE_W-1:0] CODE_PUT_ACK = 4'd6;
    localparam logic [CODE_W-1:0] CODE_DIR_DAT = 4'd7;
    localparam logic [CODE_W-1:0] CODE_OWN_DAT = 4'd8;
    localparam logic [CODE_W-1:0] CODE_INV_ACK = 4'd9;

    typedef enum logic [3:0] {
        EV_NONE, EV_LOAD, EV_STORE, EV_REPL, EV_FWD_RD, EV_FWD_OWN,
        EV_INV, EV_PUT_ACK, EV_DATA_NOACK, EV_DATA_ACKS, EV_DATA_OWNER,
        EV_INV_ACK, EV_BAD
    } event_e;

    typedef enum logic [1:0] {
        CNT_HOLD, CNT_CLEAR, CNT_ADD, CNT_DEC
    } cnt_op_e;

    typedef struct packed {
        logic load_hit;
        logic store_hit;
        logic gets;
        logic getm;
        logic puts;
        logic putm;
        logic data_req;
        logic data_dir;
        logic inv_ack;
        logic last_ack;
    } action_t;

    function automatic perm_e perm_of(line_state_e s);
        case (s)
            ST_I:                          return PERM_ABSENT;
            ST_IS_D, ST_IM_AD, ST_II_A:    return PERM_INVALID;
            ST_IM_A, ST_MI_A, ST_SI_A:     return PERM_BUSY;
            ST_S, ST_SM_AD, ST_SM_A:       return PERM_RO;
            ST_M:                          return PERM_RW;
            default:                       return PERM_ABSENT;
        endcase
    endfunction

endpackage

// File: rtl/msi_l1_event_decode.sv
module msi_l1_event_decode
    import msi_l1_pkg::*;
#(
    parameter int ACK_W = 8
) (
    input  logic                    valid,
    input  logic [CODE_W-1:0]       code,
    input  logic signed [ACK_W-1:0] acks,
    output event_e                  ev
);
    always_comb begin
        if (!valid) begin
            ev = EV_NONE;
        end else begin
            case (code)
                CODE_LOAD:    ev = EV_LOAD;
                CODE_STORE:   ev = EV_STORE;
                CODE_REPL:    ev = EV_REPL;
                CODE_FWD_RD:  ev = EV_FWD_RD;
                CODE_FWD_OWN: ev = EV_FWD_OWN;
                CODE_INV:     ev = EV_INV;
                CODE_PUT_ACK: ev = EV_PUT_ACK;
                CODE_DIR_DAT: ev = (acks == '0) ? EV_DATA_NOACK : EV_DATA_ACKS;
                CODE_OWN_DAT: ev = EV_DATA_OWNER;
                CODE_INV_ACK: ev = EV_INV_ACK;
                default:      ev = EV_BAD;
            endcase
        end
    end
endmodule

// File: rtl/msi_l1_ack_counter.sv
module msi_l1_ack_counter
    import msi_l1_pkg::*;
#(
    parameter int ACK_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  cnt_op_e                 op,
    input  logic signed [ACK_W-1:0] delta,
    output logic signed [ACK_W-1:0] cnt,
    output logic                    add_zero,
    output logic                    dec_zero
);
    localparam logic signed [ACK_W-1:0] ONE = ACK_W'(1);

    logic signed [ACK_W-1:0] sum_v;
    logic signed [ACK_W-1:0] dec_v;

    assign sum_v    = cnt + delta;
    assign dec_v    = cnt - ONE;
    assign add_zero = (sum_v == '0);
    assign dec_zero = (dec_v == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else begin
            case (op)
                CNT_CLEAR: cnt <= '0;
                CNT_ADD:   cnt <= sum_v;
                CNT_DEC:   cnt <= dec_v;
                default:   cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/msi_l1_transition.sv
module msi_l1_transition
    import msi_l1_pkg::*;
(
    input  line_state_e cur,
    input  event_e      ev,
    input  logic        add_zero,
    input  logic        dec_zero,
    output line_state_e nxt,
    output action_t     act,
    output cnt_op_e     op,
    output logic        stall,
    output logic        bad
);
    logic is_transient;
    logic fwd_wait;

    assign is_transient = !(cur inside {ST_I, ST_S, ST_M});
    assign fwd_wait     = cur inside {ST_IM_AD, ST_IM_A, ST_SM_AD, ST_SM_A};

    always_comb begin
        nxt   = cur;
        act   = '0;
        op    = CNT_HOLD;
        stall = 1'b0;
        bad   = 1'b0;
        case (ev)
            EV_NONE: ;
            EV_LOAD: begin
                if (cur == ST_I) begin
                    act.gets = 1'b1;
                    nxt      = ST_IS_D;
                end else if (cur inside {ST_S, ST_SM_AD, ST_SM_A, ST_M}) begin
                    act.load_hit = 1'b1;
                end else begin
                    stall = 1'b1;
                end
            end
            EV_STORE: begin
                if (cur == ST_I) begin
                    act.getm = 1'b1;
                    nxt      = ST_IM_AD;
                end else if (cur == ST_S) begin
                    act.getm = 1'b1;
                    nxt      = ST_SM_AD;
                end else if (cur == ST_M) begin
                    act.store_hit = 1'b1;
                end else begin
                    stall = 1'b1;
                end
            end
            EV_REPL: begin
                if (cur == ST_S) begin
                    act.puts = 1'b1;
                    nxt      = ST_SI_A;
                end else if (cur == ST_M) begin
                    act.putm = 1'b1;
                    nxt      = ST_MI_A;
                end else if (is_transient) begin
                    stall = 1'b1;
                end else begin
                    bad = 1'b1;
                end
            end
            EV_FWD_RD, EV_FWD_OWN: begin
                if (cur == ST_M || cur == ST_MI_A) begin
                    act.data_req = 1'b1;
                    if (ev == EV_FWD_RD) begin
                        act.data_dir = 1'b1;
                        nxt = (cur == ST_M) ? ST_S : ST_SI_A;
                    end else begin
                        nxt = (cur == ST_M) ? ST_I : ST_II_A;
                    end
                end else if (fwd_wait) begin
                    stall = 1'b1;
                end else begin
                    bad = 1'b1;
                end
            end
            EV_INV: begin
                case (cur)
                    ST_S:     begin act.inv_ack = 1'b1; nxt = ST_I;     end
                    ST_SM_AD: begin act.inv_ack = 1'b1; nxt = ST_IM_AD; end
                    ST_SI_A:  begin act.inv_ack = 1'b1; nxt = ST_II_A;  end
                    ST_IS_D:  stall = 1'b1;
                    default:  bad = 1'b1;
                endcase
            end
            EV_PUT_ACK: begin
                if (cur inside {ST_MI_A, ST_SI_A, ST_II_A}) nxt = ST_I;
                else bad = 1'b1;
            end
            EV_DATA_NOACK, EV_DATA_OWNER: begin
                if (cur == ST_IS_D) begin
                    act.load_hit = 1'b1;
                    nxt          = ST_S;
                end else if (cur == ST_IM_AD || cur == ST_SM_AD) begin
                    act.store_hit = 1'b1;
                    nxt           = ST_M;
                    op            = CNT_CLEAR;
                end else begin
                    bad = 1'b1;
                end
            end
            EV_DATA_ACKS: begin
                if (cur == ST_IM_AD || cur == ST_SM_AD) begin
                    if (add_zero) begin
                        act.store_hit = 1'b1;
                        act.last_ack  = 1'b1;
                        nxt           = ST_M;
                        op            = CNT_CLEAR;
                    end else begin
                        nxt = (cur == ST_IM_AD) ? ST_IM_A : ST_SM_A;
                        op  = CNT_ADD;
                    end
                end else begin
                    bad = 1'b1;
                end
            end
            EV_INV_ACK: begin
                if (cur == ST_IM_AD || cur == ST_SM_AD) begin
                    op = CNT_DEC;
                end else if (cur == ST_IM_A || cur == ST_SM_A) begin
                    if (dec_zero) begin
                        act.store_hit = 1'b1;
                        act.last_ack  = 1'b1;
                        nxt           = ST_M;
                        op            = CNT_CLEAR;
                    end else begin
                        op = CNT_DEC;
                    end
                end else begin
                    bad = 1'b1;
                end
            end
            default: bad = 1'b1;
        endcase
    end
endmodule

// File: rtl/msi_l1_line_ctrl.sv
module msi_l1_line_ctrl
    import msi_l1_pkg::*;
#(
    parameter int ACK_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ev_valid,
    input  logic [3:0]              ev_code,
    input  logic signed [ACK_W-1:0] ev_acks,
    output logic [3:0]              state_o,
    output logic [2:0]              perm_o,
    output logic signed [ACK_W-1:0] ack_cnt_o,
    output logic                    stall_o,
    output logic                    load_hit_o,
    output logic                    store_hit_o,
    output logic                    req_gets_o,
    output logic                    req_getm_o,
    output logic                    req_puts_o,
    output logic                    req_putm_o,
    output logic                    rsp_data_req_o,
    output logic                    rsp_data_dir_o,
    output logic                    rsp_inv_ack_o,
    output logic                    last_ack_o,
    output logic                    protocol_error_o
);
    line_state_e state_q;
    line_state_e state_d;
    event_e      ev;
    action_t     act;
    cnt_op_e     op;
    logic        add_zero;
    logic        dec_zero;
    logic        bad;
    logic        err_q;

    msi_l1_event_decode #(.ACK_W(ACK_W)) u_decode (
        .valid (ev_valid),
        .code  (ev_code),
        .acks  (ev_acks),
        .ev    (ev)
    );

    msi_l1_ack_counter #(.ACK_W(ACK_W)) u_acks (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .delta    (ev_acks),
        .cnt      (ack_cnt_o),
        .add_zero (add_zero),
        .dec_zero (dec_zero)
    );

    msi_l1_transition u_table (
        .cur      (state_q),
        .ev       (ev),
        .add_zero (add_zero),
        .dec_zero (dec_zero),
        .nxt      (state_d),
        .act      (act),
        .op       (op),
        .stall    (stall_o),
        .bad      (bad)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_I;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (bad) err_q <= 1'b1;
        end
    end

    assign state_o          = state_q;
    assign perm_o           = perm_of(state_q);
    assign protocol_error_o = err_q;
    assign load_hit_o       = act.load_hit;
    assign store_hit_o      = act.store_hit;
    assign req_gets_o       = act.gets;
    assign req_getm_o       = act.getm;
    assign req_puts_o       = act.puts;
    assign req_putm_o       = act.putm;
    assign rsp_data_req_o   = act.data_req;
    assign rsp_data_dir_o   = act.data_dir;
    assign rsp_inv_ack_o    = act.inv_ack;
    assign last_ack_o       = act.last_ack;

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        $past(protocol_error_o) |-> protocol_error_o);

    assert_bad_keeps_state_R10: assert property (@(posedge clk) disable iff (rst)
        bad |=> (state_o == $past(state_o)) && (ack_cnt_o == $past(ack_cnt_o)));

    assert_stall_keeps_state_R9: assert property (@(posedge clk) disable iff (rst)
        stall_o |=> (state_o == $past(state_o)) && (ack_cnt_o == $past(ack_cnt_o)));

    assert_one_request_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({req_gets_o, req_getm_o, req_puts_o, req_putm_o}));

    assert_last_ack_to_m_R5: assert property (@(posedge clk) disable iff (rst)
        last_ack_o |=> (state_o == ST_M) && (ack_cnt_o == '0));

    assert_stable_count_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (state_o inside {ST_I, ST_S, ST_M}) |-> (ack_cnt_o == '0));

    assert_owner_only_data_R6: assert property (@(posedge clk) disable iff (rst)
        rsp_data_req_o |-> (state_o == ST_M || state_o == ST_MI_A));
endmodule

// File: tb/msi_l1_line_ctrl_tb.sv
module msi_l1_line_ctrl_tb;
    localparam int B_STALL = 10, B_LH = 9, B_SH = 8, B_GETS = 7, B_GETM = 6,
                   B_PUTS = 5, B_PUTM = 4, B_DREQ = 3, B_DDIR = 2, B_IACK = 1,
                   B_LAST = 0;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ev_valid = 1'b0;
    logic [3:0] ev_code = '0;
    logic signed [7:0] ev_acks = '0;
    logic [3:0] state_o;
    logic [2:0] perm_o;
    logic signed [7:0] ack_cnt_o;
    logic stall_o, load_hit_o, store_hit_o, req_gets_o, req_getm_o;
    logic req_puts_o, req_putm_o, rsp_data_req_o, rsp_data_dir_o;
    logic rsp_inv_ack_o, last_ack_o, protocol_error_o;

    int checks = 0;
    int fails = 0;
    int ms = 0;
    int mc = 0;
    bit merr = 1'b0;

    always #2 clk = ~clk;

    msi_l1_line_ctrl u_dut (
        .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_code(ev_code),
        .ev_acks(ev_acks), .state_o(state_o), .perm_o(perm_o),
        .ack_cnt_o(ack_cnt_o), .stall_o(stall_o), .load_hit_o(load_hit_o),
        .store_hit_o(store_hit_o), .req_gets_o(req_gets_o),
        .req_getm_o(req_getm_o), .req_puts_o(req_puts_o),
        .req_putm_o(req_putm_o), .rsp_data_req_o(rsp_data_req_o),
        .rsp_data_dir_o(rsp_data_dir_o), .rsp_inv_ack_o(rsp_inv_ack_o),
        .last_ack_o(last_ack_o), .protocol_error_o(protocol_error_o)
    );

    function automatic int model_perm(int s);
        if (s == 0) return 0;
        if (s == 1 || s == 2 || s == 10) return 1;
        if (s == 3 || s == 8 || s == 9) return 2;
        if (s == 4 || s == 5 || s == 6) return 3;
        return 4;
    endfunction

    task automatic model_eval(input bit v, input int code, input int acks,
                              output logic [10:0] ex, output int nms,
                              output int nmc, output bit bad);
        ex = '0; nms = ms; nmc = mc; bad = 1'b0;
        if (v) begin
            case (code)
                0: if (ms == 0) begin ex[B_GETS] = 1; nms = 1; end
                   else if (ms >= 4 && ms <= 7) ex[B_LH] = 1;
                   else ex[B_STALL] = 1;
                1: if (ms == 0) begin ex[B_GETM] = 1; nms = 2; end
                   else if (ms == 4) begin ex[B_GETM] = 1; nms = 5; end
                   else if (ms == 7) ex[B_SH] = 1;
                   else ex[B_STALL] = 1;
                2: if (ms == 4) begin ex[B_PUTS] = 1; nms = 9; end
                   else if (ms == 7) begin ex[B_PUTM] = 1; nms = 8; end
                   else if (ms == 0) bad = 1;
                   else ex[B_STALL] = 1;
                3, 4: if (ms == 7 || ms == 8) begin
                         ex[B_DREQ] = 1;
                         if (code == 3) begin ex[B_DDIR] = 1; nms = (ms == 7) ? 4 : 9; end
                         else nms = (ms == 7) ? 0 : 10;
                      end else if (ms == 2 || ms == 3 || ms == 5 || ms == 6) ex[B_STALL] = 1;
                      else bad = 1;
                5: if (ms == 4) begin ex[B_IACK] = 1; nms = 0; end
                   else if (ms == 5) begin ex[B_IACK] = 1; nms = 2; end
                   else if (ms == 9) begin ex[B_IACK] = 1; nms = 10; end
                   else if (ms == 1) ex[B_STALL] = 1;
                   else bad = 1;
                6: if (ms >= 8 && ms <= 10) nms = 0; else bad = 1;
                7, 8: if (code == 8 || acks == 0) begin
                         if (ms == 1) begin ex[B_LH] = 1; nms = 4; end
                         else if (ms == 2 || ms == 5) begin ex[B_SH] = 1; nms = 7; nmc = 0; end
                         else bad = 1;
                      end else if (ms == 2 || ms == 5) begin
                         if (mc + acks == 0) begin
                             ex[B_SH] = 1; ex[B_LAST] = 1; nms = 7; nmc = 0;
                         end else begin
                             nms = ms + 1; nmc = mc + acks;
                         end
                      end else bad = 1;
                9: if (ms == 2 || ms == 5) nmc = mc - 1;
                   else if (ms == 3 || ms == 6) begin
                       if (mc - 1 == 0) begin
                           ex[B_SH] = 1; ex[B_LAST] = 1; nms = 7; nmc = 0;
                       end else nmc = mc - 1;
                   end else bad = 1;
                default: bad = 1;
            endcase
        end
        if (bad) begin ex = '0; nms = ms; nmc = mc; end
    endtask

    task automatic step(input bit v, input int code, input int acks, input string tag);
        logic [10:0] ex;
        logic [10:0] got;
        int nms, nmc;
        bit bad;
        @(negedge clk);
        ev_valid = v; ev_code = 4'(code); ev_acks = 8'(acks);
        #1;
        model_eval(v, code, acks, ex, nms, nmc, bad);
        got = {stall_o, load_hit_o, store_hit_o, req_gets_o, req_getm_o,
               req_puts_o, req_putm_o, rsp_data_req_o, rsp_data_dir_o,
               rsp_inv_ack_o, last_ack_o};
        checks++;
        if (int'(state_o) != ms || int'(perm_o) != model_perm(ms) ||
            int'(ack_cnt_o) != mc || protocol_error_o != merr || got != ex) begin
            fails++;
            $display("FAIL %s code=%0d: got st=%0d perm=%0d cnt=%0d err=%0b out=%b exp st=%0d perm=%0d cnt=%0d err=%0b out=%b",
                     tag, code, state_o, perm_o, ack_cnt_o, protocol_error_o, got,
                     ms, model_perm(ms), mc, merr, ex);
        end
        @(posedge clk);
        ms = nms; mc = nmc;
        if (bad) merr = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (state_o != 4'd0 || perm_o != 3'd0 || ack_cnt_o != 8'sd0 ||
            protocol_error_o || stall_o || req_gets_o || req_getm_o) begin
            fails++;
            $display("FAIL R1: reset got st=%0d perm=%0d cnt=%0d err=%0b exp st=0 perm=0 cnt=0 err=0",
                     state_o, perm_o, ack_cnt_o, protocol_error_o);
        end
        rst = 1'b0;

        // R3 R4: read fill, stall while filling
        step(1, 0, 0, "R3");
        step(1, 0, 0, "R9");
        step(1, 5, 0, "R9");
        step(1, 7, 0, "R4");
        step(1, 0, 0, "R3");
        step(0, 0, 0, "R10");
        // R5: upgrade with an early ack, then data with a count
        step(1, 1, 0, "R3");
        step(1, 0, 0, "R3");
        step(1, 9, 0, "R5");
        step(1, 7, 3, "R4");
        step(1, 1, 0, "R9");
        step(1, 3, 0, "R9");
        step(1, 9, 0, "R5");
        step(1, 9, 0, "R5");
        step(1, 1, 0, "R3");
        // R6 downgrade, R8 invalidate during upgrade
        step(1, 3, 0, "R6");
        step(1, 1, 0, "R3");
        step(1, 5, 0, "R8");
        step(1, 8, 0, "R4");
        // R7 writeback race with fwd-own
        step(1, 2, 0, "R7");
        step(1, 0, 0, "R9");
        step(1, 4, 0, "R6");
        step(1, 6, 0, "R7");
        // R5 early acks cancel data count exactly
        step(1, 1, 0, "R3");
        step(1, 9, 0, "R5");
        step(1, 9, 0, "R5");
        step(1, 7, 2, "R5");
        step(1, 4, 0, "R6");
        // R7 R8 clean eviction race
        step(1, 0, 0, "R3");
        step(1, 8, 0, "R4");
        step(1, 2, 0, "R7");
        step(1, 5, 0, "R8");
        step(1, 6, 0, "R7");
        step(1, 0, 0, "R3");
        step(1, 7, 0, "R4");
        step(1, 5, 0, "R8");
        // R6 writeback race with fwd-read
        step(1, 1, 0, "R3");
        step(1, 7, 0, "R4");
        step(1, 2, 0, "R7");
        step(1, 3, 0, "R6");
        step(1, 6, 0, "R7");
        // R2 busy permission while waiting acks
        step(1, 1, 0, "R3");
        step(1, 7, 1, "R4");
        step(1, 0, 0, "R2");
        step(1, 4, 0, "R9");
        step(1, 9, 0, "R5");
        // R10 illegal pairs and codes
        step(1, 3, 0, "R10");
        step(1, 12, 0, "R10");
        step(1, 6, 0, "R10");
        step(1, 2, 0, "R7");
        step(1, 9, 0, "R10");
        step(1, 6, 0, "R7");
        step(1, 4, 0, "R10");
        step(1, 15, 0, "R10");
        step(1, 0, 0, "R3");
        step(1, 7, 4, "R10");
        step(1, 7, 0, "R4");
        step(0, 0, 0, "R10");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule